// File: doc/BRIEF.md
# Table-scheduled CORDIC vector rotator

This block turns a two's-complement vector (x, y) through a signed angle z with a sequence of shift-and-add micro-rotations, performing one micro-rotation per clock. The shift used by each step comes from a fixed schedule table rather than from the step number. The schedule starts at a shift of 1, which removes the usual 45-degree first step while still covering every angle up to ±45 degrees. The result is 11 steps where a plain schedule needs 12 to reach the same final angle error. The gain that the schedule builds up is removed by one multiply by a fixed constant, and that multiply is itself a sum of shifted copies.

The host writes x, y and angle and pulses start while the unit is idle. A done pulse marks the moment the rotated vector and the leftover angle are valid, and they stay valid until the next done. Loading x = 1.0 and y = 0 makes the outputs the cosine and sine of the angle. Vectors use Q2.14 format, so 1.0 is 16384. Angles use a 16-bit turn fraction, so one LSB is 360/65536 degree and ±8192 is ±45 degrees.

Top module: `cordic_rot`

## Requirements
- R1: After reset, busy_o, done_o and range_err_o are low and x_o, y_o and z_o are zero.
- R2: The rotation makes 11 micro-rotations with shifts 1, 2, ..., 11. Each step takes direction +1 when the internal residual angle is zero or positive and -1 otherwise, and the result is multiplied by the fixed gain 0.858785. For a general vector v, each output is within |v|·0.000646 + 4 LSB of the exact rotation.
- R3: With x_i = 16384 and y_i = 0, x_o and y_o are within 13 LSB of 16384·cos(z) and 16384·sin(z) for every angle from -8192 to +8192 inclusive.
- R4: For every accepted angle, the residual z_o is within ±6 LSB, which is no more than 0.037 degree.
- R5: For an accepted start, done_o is a one-cycle pulse in the 13th cycle after the cycle in which start_i was sampled. x_o, y_o and z_o change only when done_o rises and then hold their values.
- R6: busy_o is high from the cycle after an accepted start until done_o rises. A start_i pulse while busy_o is high has no effect on the result or the timing of the operation in flight.
- R7: An angle with |z_i| > 8192 is rejected. In the cycle after start, done_o and range_err_o pulse together, busy_o stays low, and x_o, y_o and z_o keep their previous values. The angles ±8192 are accepted.
- R8: Outputs that exceed the signed 16-bit range saturate to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation when idle |
| x_i | input | 16 | Input x, Q2.14 signed |
| y_i | input | 16 | Input y, Q2.14 signed |
| z_i | input | 16 | Rotation angle, signed turn fraction |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| range_err_o | output | 1 | Pulses with done_o when the angle was rejected |
| x_o | output | 16 | Rotated x, saturated |
| y_o | output | 16 | Rotated y, saturated |
| z_o | output | 16 | Residual angle |

## Verification
An accepted start produces done_o 13 cycles after the cycle in which start_i is sampled, and a rejected angle produces it in the very next cycle. The bench counts negative edges from the start cycle until done_o is seen, and it checks that count against 13 or 1 for every operation. Results are read on the negative edge on which done_o is first seen, and they are read again a few cycles later to confirm they hold. All inputs change on negative edges, so no sample falls on the active edge.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;
  localparam int unsigned NUM_ITER = 11;
  localparam int unsigned IDX_W    = $clog2(NUM_ITER);
  localparam int unsigned SH_W     = 5;
  // arctangent table scale: 2^-ATAN_FB of a full turn
  localparam int unsigned ATAN_FB  = 20;
  // gain of the schedule below, unsigned with GAIN_FB fraction bits
  localparam int unsigned GAIN_FB  = 18;
  localparam int unsigned GAIN_Q   = 225125;

  function automatic logic [SH_W-1:0] shift_of(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return 5'd1;
      4'd1:    return 5'd2;
      4'd2:    return 5'd3;
      4'd3:    return 5'd4;
      4'd4:    return 5'd5;
      4'd5:    return 5'd6;
      4'd6:    return 5'd7;
      4'd7:    return 5'd8;
      4'd8:    return 5'd9;
      4'd9:    return 5'd10;
      default: return 5'd11;
    endcase
  endfunction

  // atan(2^-shift_of(i)) in units of 2^-ATAN_FB turn
  function automatic int atan_of(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return 77376;
      4'd1:    return 40884;
      4'd2:    return 20753;
      4'd3:    return 10417;
      4'd4:    return 5213;
      4'd5:    return 2607;
      4'd6:    return 1304;
      4'd7:    return 652;
      4'd8:    return 326;
      4'd9:    return 163;
      default: return 81;
    endcase
  endfunction
endpackage

// File: rtl/cordic_rot_table.sv
module cordic_rot_table
  import cordic_rot_pkg::*;
#(
  parameter int unsigned ZW = 20
) (
  input  logic [IDX_W-1:0]     idx_i,
  output logic [SH_W-1:0]      sh_o,
  output logic signed [ZW-1:0] atan_o
);
  int raw;

  always_comb begin
    sh_o = shift_of(idx_i);
    raw  = atan_of(idx_i);
  end

  generate
    if (ZW >= ATAN_FB) begin : g_up
      assign atan_o = ZW'(raw) <<< (ZW - ATAN_FB);
    end else begin : g_dn
      assign atan_o = ZW'(raw >>> (ATAN_FB - ZW));
    end
  endgenerate
endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage #(
  parameter int unsigned IW   = 22,
  parameter int unsigned ZW   = 20,
  parameter int unsigned SH_W = 5
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic [SH_W-1:0]      sh_i,
  input  logic signed [ZW-1:0] atan_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic                 dir_pos;
  logic signed [IW-1:0] xs, ys;

  always_comb begin
    dir_pos = ~z_i[ZW-1];
    xs      = x_i >>> sh_i;
    ys      = y_i >>> sh_i;
    if (dir_pos) begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - atan_i;
    end else begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + atan_i;
    end
  end
endmodule

// File: rtl/cordic_rot_gain.sv
module cordic_rot_gain
  import cordic_rot_pkg::*;
#(
  parameter int unsigned IW = 22,
  parameter int unsigned DW = 16,
  parameter int unsigned FR = 4
) (
  input  logic signed [IW-1:0] v_i,
  output logic signed [DW-1:0] v_o
);
  localparam int unsigned PW  = IW + GAIN_FB;
  localparam int unsigned SHR = GAIN_FB + FR;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SHR - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW - 1));

  logic signed [PW-1:0] acc, q;

  always_comb begin
    acc = '0;
    for (int b = 0; b < int'(GAIN_FB); b++) begin
      if (GAIN_Q[b]) acc = acc + (PW'(v_i) <<< b);
    end
    q = (acc + HALF) >>> SHR;
    if (q > MAXV)      v_o = MAXV[DW-1:0];
    else if (q < MINV) v_o = MINV[DW-1:0];
    else               v_o = q[DW-1:0];
  end
endmodule

// File: rtl/cordic_rot.sv
module cordic_rot
  import cordic_rot_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [AW-1:0] z_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 range_err_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o
);
  localparam int unsigned GB = 2;
  localparam int unsigned FR = $clog2(NUM_ITER);
  localparam int unsigned IW = DW + GB + FR;
  localparam int unsigned ZW = AW + FR;
  localparam logic signed [AW-1:0] ANG_LIM = AW'(1) <<< (AW - 3);
  localparam logic signed [ZW-1:0] Z_HALF  = ZW'(1) <<< (FR - 1);
  // 0.037 degree in internal angle LSB
  localparam logic signed [ZW-1:0] RES_BND = ZW'((longint'(37) <<< (AW + FR)) / 360000);

  logic signed [IW-1:0] x_q, y_q, x_n, y_n;
  logic signed [ZW-1:0] z_q, z_n, atan_v, z_rnd;
  logic [SH_W-1:0]      sh_v;
  logic [IDX_W-1:0]     cnt_q;
  logic                 run_q, fin_q, done_q, err_q, last, in_range, accept;
  logic signed [DW-1:0] gx, gy, xo_q, yo_q;
  logic signed [AW-1:0] zo_q;
  logic                 unused_zlo;

  cordic_rot_table #(.ZW(ZW)) u_table (
    .idx_i (cnt_q),
    .sh_o  (sh_v),
    .atan_o(atan_v)
  );

  cordic_rot_stage #(.IW(IW), .ZW(ZW), .SH_W(SH_W)) u_stage (
    .x_i   (x_q),
    .y_i   (y_q),
    .z_i   (z_q),
    .sh_i  (sh_v),
    .atan_i(atan_v),
    .x_o   (x_n),
    .y_o   (y_n),
    .z_o   (z_n)
  );

  cordic_rot_gain #(.IW(IW), .DW(DW), .FR(FR)) u_gain_x (.v_i(x_q), .v_o(gx));
  cordic_rot_gain #(.IW(IW), .DW(DW), .FR(FR)) u_gain_y (.v_i(y_q), .v_o(gy));

  assign last       = (cnt_q == IDX_W'(NUM_ITER - 1));
  assign in_range   = (z_i <= ANG_LIM) && (z_i >= -ANG_LIM);
  assign accept     = start_i && !run_q && !fin_q;
  assign z_rnd      = z_q + Z_HALF;
  assign unused_zlo = ^z_rnd[FR-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      xo_q   <= '0;
      yo_q   <= '0;
      zo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (run_q) begin
        x_q   <= x_n;
        y_q   <= y_n;
        z_q   <= z_n;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end else if (fin_q) begin
        fin_q  <= 1'b0;
        done_q <= 1'b1;
        xo_q   <= gx;
        yo_q   <= gy;
        zo_q   <= z_rnd[ZW-1:FR];
      end else if (accept) begin
        if (in_range) begin
          x_q   <= {{GB{x_i[DW-1]}}, x_i, {FR{1'b0}}};
          y_q   <= {{GB{y_i[DW-1]}}, y_i, {FR{1'b0}}};
          z_q   <= {z_i, {FR{1'b0}}};
          cnt_q <= '0;
          run_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = run_q | fin_q;
  assign done_o      = done_q;
  assign range_err_o = err_q;
  assign x_o         = xo_q;
  assign y_o         = yo_q;
  assign z_o         = zo_q;

  // R4: leftover angle after the last micro-rotation
  a_r4_residual_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> (z_q <= RES_BND) && (z_q >= -RES_BND));

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5: a finished iteration run reports a normal result next cycle
  a_r5_fin_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> done_o && !range_err_o);

  // R6: start during a run does not disturb the step counter
  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !last && start_i) |=> run_q && (cnt_q == IDX_W'($past(cnt_q) + 1'b1)));

  // R6: busy has dropped when done is shown
  a_r6_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7: rejected angle
  a_r7_range_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range) |=> done_o && range_err_o && !busy_o
                              && $stable(x_o) && $stable(y_o) && $stable(z_o));
endmodule

// File: tb/tb_cordic_rot.sv
module tb_cordic_rot;
  localparam int  CLK_PERIOD = 10;
  localparam int  LAT_OK     = 13;
  localparam int  LAT_ERR    = 1;
  localparam real PI         = 3.14159265358979;
  localparam real DEG_BND    = 0.000646;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic signed [15:0] x_i = '0, y_i = '0, z_i = '0;
  logic               busy_o, done_o, range_err_o;
  logic signed [15:0] x_o, y_o, z_o;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 1'b0;

  cordic_rot dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .busy_o(busy_o), .done_o(done_o), .range_err_o(range_err_o),
    .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait (cycles >= 190000);
    failures++;
    $display("FAIL watchdog expired act=%0d exp<190000", cycles);
    summary();
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0f exp=%0f", req, act, exp);
    end
  endtask

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  function automatic real sat(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  task automatic run_op(input int xv, input int yv, input int zv,
                        output int lat, output int xo, output int yo,
                        output int zo, output bit er);
    @(negedge clk_i);
    x_i = 16'(xv); y_i = 16'(yv); z_i = 16'(zv);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
    xo = x_o; yo = y_o; zo = z_o; er = range_err_o;
  endtask

  task automatic rot_check(input int xv, input int yv, input int zv,
                           input real tol, input string req);
    int lat, xo, yo, zo;
    bit er;
    real a, ex, ey;
    run_op(xv, yv, zv, lat, xo, yo, zo, er);
    a  = real'(zv) * 2.0 * PI / 65536.0;
    ex = sat(real'(xv) * $cos(a) - real'(yv) * $sin(a));
    ey = sat(real'(xv) * $sin(a) + real'(yv) * $cos(a));
    chk(lat == LAT_OK && !er, "R5 latency", real'(lat), real'(LAT_OK));
    chk(rabs(real'(xo) - ex) <= tol, {req, " x"}, real'(xo), ex);
    chk(rabs(real'(yo) - ey) <= tol, {req, " y"}, real'(yo), ey);
    chk(zo <= 6 && zo >= -6, "R4 residual", real'(zo), 0.0);
  endtask

  initial begin
    int lat, xo, yo, zo, px, py, pz;
    bit er;
    real tol, a;
    #(3*CLK_PERIOD + 2);
    // R1 reset state
    chk(!busy_o && !done_o && !range_err_o, "R1 flags", real'(busy_o + done_o + range_err_o), 0.0);
    chk(x_o == 0 && y_o == 0 && z_o == 0, "R1 outputs", real'(x_o + y_o + z_o), 0.0);
    rst_ni = 1'b1;

    // R3 unit vector sweep over the full angle range
    for (int z = -8192; z <= 8192; z += 32) rot_check(16384, 0, z, 13.0, "R3 sincos");
    for (int z = -8192; z <= -8188; z++) rot_check(16384, 0, z, 13.0, "R3 low edge");
    for (int z = 8188; z <= 8192; z++) rot_check(16384, 0, z, 13.0, "R3 high edge");
    for (int z = -2; z <= 2; z++) rot_check(16384, 0, z, 13.0, "R3 near zero");

    // R2 general vectors
    for (int p = 0; p < 4; p++) begin
      int xv, yv;
      case (p)
        0: begin xv = 10000;  yv = 5000;   end
        1: begin xv = -12000; yv = 7000;   end
        2: begin xv = 3000;   yv = -20000; end
        default: begin xv = -15000; yv = -15000; end
      endcase
      tol = $sqrt(real'(xv) * real'(xv) + real'(yv) * real'(yv)) * DEG_BND + 4.0;
      for (int z = -8192; z <= 8192; z += 512) rot_check(xv, yv, z, tol, "R2 vector");
    end

    // R8 saturation
    run_op(32767, 32767, 8192, lat, xo, yo, zo, er);
    chk(yo == 32767, "R8 sat high y", real'(yo), 32767.0);
    chk(xo <= 40 && xo >= -40, "R8 x near zero", real'(xo), 0.0);
    run_op(32767, 32767, -8192, lat, xo, yo, zo, er);
    chk(xo == 32767, "R8 sat high x", real'(xo), 32767.0);
    run_op(-32768, -32768, 8192, lat, xo, yo, zo, er);
    chk(yo == -32768, "R8 sat low y", real'(yo), -32768.0);

    // R5 outputs hold after done
    run_op(16384, 0, 3000, lat, px, py, pz, er);
    repeat (4) @(negedge clk_i);
    chk(x_o == px && y_o == py && z_o == pz, "R5 hold", real'(x_o), real'(px));

    // R7 out-of-range angles: outputs unchanged
    for (int k = 0; k < 4; k++) begin
      int zv;
      case (k)
        0: zv = 8193;
        1: zv = -8193;
        2: zv = 32767;
        default: zv = -32768;
      endcase
      run_op(1000, 2000, zv, lat, xo, yo, zo, er);
      chk(lat == LAT_ERR && er, "R7 reject timing", real'(lat), real'(LAT_ERR));
      chk(xo == px && yo == py && zo == pz, "R7 outputs kept", real'(xo), real'(px));
      chk(!busy_o, "R7 not busy", real'(busy_o), 0.0);
    end

    // R6 start ignored while busy
    @(negedge clk_i);
    x_i = 16384; y_i = 0; z_i = 4000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R6 busy after start", real'(busy_o), 1.0);
    lat = 1;
    repeat (2) begin @(negedge clk_i); lat++; end
    x_i = 0; y_i = 9000; z_i = -7000; start_i = 1'b1;
    @(negedge clk_i); lat++;
    start_i = 1'b0;
    chk(busy_o, "R6 still busy", real'(busy_o), 1.0);
    while (!done_o && lat < 60) begin @(negedge clk_i); lat++; end
    a = 4000.0 * 2.0 * PI / 65536.0;
    chk(lat == LAT_OK, "R6 timing kept", real'(lat), real'(LAT_OK));
    chk(rabs(real'(x_o) - 16384.0 * $cos(a)) <= 13.0, "R6 x unchanged", real'(x_o), 16384.0 * $cos(a));
    chk(rabs(real'(y_o) - 16384.0 * $sin(a)) <= 13.0, "R6 y unchanged", real'(y_o), 16384.0 * $sin(a));
    chk(!busy_o, "R6 busy clear at done", real'(busy_o), 0.0);
    @(negedge clk_i);
    chk(!done_o, "R5 single pulse", real'(done_o), 0.0);

    summary();
  end
endmodule